// File: doc/BRIEF.md
# Debug Register Access Controller

This block sits between an instruction pipeline and a processor's hardware debug facility. It serves move-to and move-from requests that name one of eight debug register numbers. Numbers 0 to 3 select breakpoint address registers. The block does not store those addresses. Their writes are forwarded on a dedicated output, and their reads return the value presented on an input by whatever unit holds them. Number 6 selects the debug status register and number 7 the debug control register. Both are stored inside the block.

Each request passes through these rules, in this order:
- Register-number aliasing, or an undefined-opcode fault when the debug-extension flag is set.
- The one-shot general-detect trap.
- Reserved-bit checking on status and control writes.

The outcome appears one clock after the strobe as exactly one of four pulses: access done, undefined opcode, general protection (error code zero), or debug trap. A faulting access changes nothing except what the general-detect trap itself updates. The address-matching logic and the exception delivery belong to other units.

Top module: `dbgreg_access_ctrl`

## Requirements
- R1: After synchronous reset the status register reads 0xFFFF0FF0 and the control register reads 0x00000400. All outputs are low or zero until a strobe arrives.
- R2: With `ext_en` low, register numbers 4 and 5 behave as 6 and 7 for both reads and writes.
- R3: With `ext_en` high, an access to number 4 or 5 raises `fault_ud` and changes no state. This check comes before the general-detect check, so a pending general-detect bit (control bit 13) stays set.
- R4: When control bit 13 is set, any other access clears control bit 13, sets status bit 13 and raises `fault_db`. The access does not complete: nothing is stored or forwarded and the read data stays zero.
- R5: A write to numbers 0 to 3 is forwarded as a one-cycle `bp_wr_en` pulse with `bp_wr_idx` equal to the number and `bp_wr_addr` equal to the full write data. No reserved-bit check applies. A read of numbers 0 to 3 returns the matching 32-bit slice of `bp_addr_in`, where slice n is bits [32n+31:32n].
- R6: A status write with bit 12 set, or a control write with any of bits 11, 12, 14 or 15 set, raises `fault_gp` and leaves both registers unchanged.
- R7: A completed status write stores the write data ORed with 0xFFFF0FF0.
- R8: A completed control write stores the write data ORed with 0x00000400. Writing bit 13 arms general-detect.
- R9: One clock after a cycle with `dr_rd` or `dr_wr` high, exactly one of `acc_done`, `fault_ud`, `fault_gp` or `fault_db` is high. Without a strobe none is high. `rd_data` carries the register value only with `acc_done` for a read and is zero otherwise.
- R10: When `dr_rd` and `dr_wr` are both high, the request is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dr_rd | input | 1 | Read strobe |
| dr_wr | input | 1 | Write strobe |
| dr_num | input | 3 | Debug register number |
| dr_wdata | input | 32 | Write data |
| ext_en | input | 1 | Debug-extension flag from the control register file |
| bp_addr_in | input | NUM_BP*32 | Current breakpoint addresses, slice n for number n |
| rd_data | output | 32 | Read result, valid with `acc_done` on reads |
| acc_done | output | 1 | Access completed |
| fault_ud | output | 1 | Undefined-opcode fault |
| fault_gp | output | 1 | General-protection fault, error code zero |
| fault_db | output | 1 | Debug trap from general-detect |
| bp_wr_en | output | 1 | Breakpoint address write forward strobe |
| bp_wr_idx | output | 2 | Breakpoint address register index |
| bp_wr_addr | output | 32 | Breakpoint address to store |

## Verification
The bench targets the ordering corner cases:
- Number 4 with `ext_en` high while general-detect is armed. A design that checked general-detect first would consume the trap and report a debug trap instead of the undefined opcode.
- General-detect armed together with a breakpoint write. A design that let the access complete after the trap would pulse the forward strobe.
- Each reserved bit set alone. A missing mask would let a write land instead of faulting.
- Reads of status and control after writes, which expose a dropped OR of the fixed-one patterns or a broken 4/5 alias.

A random sequence mixes all of these against a behavioural model.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    localparam int DW       = 32;
    localparam int NUM_W    = 3;
    localparam int BP_COUNT = 4;
    localparam int BP_IDX_W = $clog2(BP_COUNT);

    localparam logic [DW-1:0] STS_FIXED_ONES = 32'hFFFF_0FF0;
    localparam logic [DW-1:0] STS_RSVD_MASK  = 32'h0000_1000;
    localparam logic [DW-1:0] CTL_FIXED_ONES = 32'h0000_0400;
    localparam logic [DW-1:0] CTL_RSVD_MASK  = 32'h0000_D800;
    localparam logic [DW-1:0] STS_RESET      = STS_FIXED_ONES;
    localparam logic [DW-1:0] CTL_RESET      = CTL_FIXED_ONES;
    localparam int GD_BIT = 13;
    localparam int BD_BIT = 13;

    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_DONE,
        OUT_UD,
        OUT_GP,
        OUT_DB
    } outcome_e;

    typedef enum logic [1:0] {
        TGT_BP,
        TGT_STS,
        TGT_CTL
    } target_e;

    // True for the two numbers that alias onto status and control.
    function automatic logic is_alias_num(input logic [NUM_W-1:0] num);
        return (num == 3'd4) || (num == 3'd5);
    endfunction

    // Target selected by a number, after folding 4/5 onto 6/7.
    function automatic target_e target_of(input logic [NUM_W-1:0] num);
        if (!num[2])
            return TGT_BP;
        return num[0] ? TGT_CTL : TGT_STS;
    endfunction

endpackage

// File: rtl/dbgreg_decode.sv
module dbgreg_decode
    import dbgreg_pkg::*;
(
    input  logic                dr_rd,
    input  logic                dr_wr,
    input  logic [NUM_W-1:0]    dr_num,
    input  logic [DW-1:0]       dr_wdata,
    input  logic                ext_en,
    input  logic                gd_armed,
    output outcome_e            outcome,
    output logic                is_write,
    output target_e             target,
    output logic [BP_IDX_W-1:0] bp_idx
);

    logic    req;
    logic    rsvd_hit;
    target_e tgt;

    assign req      = dr_rd | dr_wr;
    assign is_write = dr_wr;
    assign tgt      = target_of(dr_num);
    assign target   = tgt;
    assign bp_idx   = dr_num[BP_IDX_W-1:0];

    always_comb begin
        case (tgt)
            TGT_STS: rsvd_hit = |(dr_wdata & STS_RSVD_MASK);
            TGT_CTL: rsvd_hit = |(dr_wdata & CTL_RSVD_MASK);
            default: rsvd_hit = 1'b0;
        endcase
    end

    // Priority: alias fault, then general-detect, then reserved bits.
    always_comb begin
        if (!req)
            outcome = OUT_NONE;
        else if (ext_en && is_alias_num(dr_num))
            outcome = OUT_UD;
        else if (gd_armed)
            outcome = OUT_DB;
        else if (dr_wr && rsvd_hit)
            outcome = OUT_GP;
        else
            outcome = OUT_DONE;
    end

endmodule

// File: rtl/dbgreg_store.sv
module dbgreg_store
    import dbgreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  outcome_e      outcome,
    input  logic          is_write,
    input  target_e       target,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sts_q,
    output logic [DW-1:0] ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= STS_RESET;
            ctl_q <= CTL_RESET;
        end else begin
            case (outcome)
                OUT_DB: begin
                    ctl_q[GD_BIT] <= 1'b0;
                    sts_q[BD_BIT] <= 1'b1;
                end
                OUT_DONE: begin
                    if (is_write && target == TGT_STS)
                        sts_q <= wdata | STS_FIXED_ONES;
                    if (is_write && target == TGT_CTL)
                        ctl_q <= wdata | CTL_FIXED_ONES;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dbgreg_resp.sv
module dbgreg_resp
    import dbgreg_pkg::*;
#(
    parameter int NUM_BP = BP_COUNT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  outcome_e               outcome,
    input  logic                   is_write,
    input  target_e                target,
    input  logic [BP_IDX_W-1:0]    bp_idx,
    input  logic [DW-1:0]          wdata,
    input  logic [DW-1:0]          sts_q,
    input  logic [DW-1:0]          ctl_q,
    input  logic [NUM_BP*DW-1:0]   bp_addr_in,
    output logic [DW-1:0]          rd_data,
    output logic                   acc_done,
    output logic                   fault_ud,
    output logic                   fault_gp,
    output logic                   fault_db,
    output logic                   bp_wr_en,
    output logic [BP_IDX_W-1:0]    bp_wr_idx,
    output logic [DW-1:0]          bp_wr_addr
);

    logic [DW-1:0] bp_sel;
    logic [DW-1:0] rd_mux;
    logic          done_now;

    always_comb begin
        bp_sel = '0;
        for (int i = 0; i < NUM_BP; i++)
            if (int'(bp_idx) == i)
                bp_sel = bp_addr_in[i*DW +: DW];
    end

    always_comb begin
        case (target)
            TGT_STS: rd_mux = sts_q;
            TGT_CTL: rd_mux = ctl_q;
            default: rd_mux = bp_sel;
        endcase
    end

    assign done_now = (outcome == OUT_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            acc_done   <= 1'b0;
            fault_ud   <= 1'b0;
            fault_gp   <= 1'b0;
            fault_db   <= 1'b0;
            bp_wr_en   <= 1'b0;
            bp_wr_idx  <= '0;
            bp_wr_addr <= '0;
        end else begin
            acc_done   <= done_now;
            fault_ud   <= (outcome == OUT_UD);
            fault_gp   <= (outcome == OUT_GP);
            fault_db   <= (outcome == OUT_DB);
            rd_data    <= (done_now && !is_write) ? rd_mux : '0;
            bp_wr_en   <= done_now && is_write && (target == TGT_BP);
            bp_wr_idx  <= bp_idx;
            bp_wr_addr <= wdata;
        end
    end

endmodule

// File: rtl/dbgreg_access_ctrl.sv
module dbgreg_access_ctrl
    import dbgreg_pkg::*;
#(
    parameter int NUM_BP = BP_COUNT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dr_rd,
    input  logic                   dr_wr,
    input  logic [NUM_W-1:0]       dr_num,
    input  logic [DW-1:0]          dr_wdata,
    input  logic                   ext_en,
    input  logic [NUM_BP*DW-1:0]   bp_addr_in,
    output logic [DW-1:0]          rd_data,
    output logic                   acc_done,
    output logic                   fault_ud,
    output logic                   fault_gp,
    output logic                   fault_db,
    output logic                   bp_wr_en,
    output logic [BP_IDX_W-1:0]    bp_wr_idx,
    output logic [DW-1:0]          bp_wr_addr
);

    outcome_e              outcome;
    logic                  is_write;
    target_e               target;
    logic [BP_IDX_W-1:0]   bp_idx;
    logic [DW-1:0]         sts_q;
    logic [DW-1:0]         ctl_q;

    dbgreg_decode u_decode (
        .dr_rd    (dr_rd),
        .dr_wr    (dr_wr),
        .dr_num   (dr_num),
        .dr_wdata (dr_wdata),
        .ext_en   (ext_en),
        .gd_armed (ctl_q[GD_BIT]),
        .outcome  (outcome),
        .is_write (is_write),
        .target   (target),
        .bp_idx   (bp_idx)
    );

    dbgreg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .outcome  (outcome),
        .is_write (is_write),
        .target   (target),
        .wdata    (dr_wdata),
        .sts_q    (sts_q),
        .ctl_q    (ctl_q)
    );

    dbgreg_resp #(.NUM_BP(NUM_BP)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .outcome    (outcome),
        .is_write   (is_write),
        .target     (target),
        .bp_idx     (bp_idx),
        .wdata      (dr_wdata),
        .sts_q      (sts_q),
        .ctl_q      (ctl_q),
        .bp_addr_in (bp_addr_in),
        .rd_data    (rd_data),
        .acc_done   (acc_done),
        .fault_ud   (fault_ud),
        .fault_gp   (fault_gp),
        .fault_db   (fault_db),
        .bp_wr_en   (bp_wr_en),
        .bp_wr_idx  (bp_wr_idx),
        .bp_wr_addr (bp_wr_addr)
    );

endmodule

// File: rtl/dbgreg_access_chk.sv
module dbgreg_access_chk
    import dbgreg_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          dr_rd,
    input logic          dr_wr,
    input logic          acc_done,
    input logic          fault_ud,
    input logic          fault_gp,
    input logic          fault_db,
    input logic          bp_wr_en,
    input logic [DW-1:0] sts_q,
    input logic [DW-1:0] ctl_q
);

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        (dr_rd || dr_wr) |=> $countones({acc_done, fault_ud, fault_gp, fault_db}) == 1);

    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !(dr_rd || dr_wr) |=> !(acc_done || fault_ud || fault_gp || fault_db || bp_wr_en));

    assert_ud_no_change_R3: assert property (@(posedge clk) disable iff (rst)
        fault_ud |-> ($stable(ctl_q) && $stable(sts_q)));

    assert_gd_consumed_R4: assert property (@(posedge clk) disable iff (rst)
        fault_db |-> (!ctl_q[GD_BIT] && sts_q[BD_BIT] && $past(ctl_q[GD_BIT])));

    assert_gd_no_forward_R4: assert property (@(posedge clk) disable iff (rst)
        bp_wr_en |-> acc_done);

    assert_gp_no_change_R6: assert property (@(posedge clk) disable iff (rst)
        fault_gp |-> ($stable(ctl_q) && $stable(sts_q)));

    assert_sts_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (sts_q & STS_FIXED_ONES) == STS_FIXED_ONES);

    assert_ctl_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q & CTL_FIXED_ONES) == CTL_FIXED_ONES);

endmodule

bind dbgreg_access_ctrl dbgreg_access_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dr_rd    (dr_rd),
    .dr_wr    (dr_wr),
    .acc_done (acc_done),
    .fault_ud (fault_ud),
    .fault_gp (fault_gp),
    .fault_db (fault_db),
    .bp_wr_en (bp_wr_en),
    .sts_q    (sts_q),
    .ctl_q    (ctl_q)
);

// File: tb/dbgreg_access_ctrl_tb.sv
module dbgreg_access_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NBP        = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dr_rd = 1'b0;
    logic              dr_wr = 1'b0;
    logic [2:0]        dr_num = '0;
    logic [31:0]       dr_wdata = '0;
    logic              ext_en = 1'b0;
    logic [NBP*32-1:0] bp_addr_in;
    logic [31:0]       rd_data;
    logic              acc_done, fault_ud, fault_gp, fault_db, bp_wr_en;
    logic [1:0]        bp_wr_idx;
    logic [31:0]       bp_wr_addr;

    logic [31:0] hold_bp [NBP];

    int checks   = 0;
    int failures = 0;

    // Behavioural reference state
    logic [31:0] m_sts, m_ctl;
    logic [31:0] m_bp [NBP];
    logic [31:0] e_rd, e_bpa;
    logic        e_done, e_ud, e_gp, e_db, e_bpw;
    logic [1:0]  e_bpi;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgreg_access_ctrl u_dut (
        .clk(clk), .rst(rst), .dr_rd(dr_rd), .dr_wr(dr_wr), .dr_num(dr_num),
        .dr_wdata(dr_wdata), .ext_en(ext_en), .bp_addr_in(bp_addr_in),
        .rd_data(rd_data), .acc_done(acc_done), .fault_ud(fault_ud),
        .fault_gp(fault_gp), .fault_db(fault_db), .bp_wr_en(bp_wr_en),
        .bp_wr_idx(bp_wr_idx), .bp_wr_addr(bp_wr_addr)
    );

    // External holder of the breakpoint addresses
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBP; i++) hold_bp[i] <= '0;
        end else if (bp_wr_en) begin
            hold_bp[bp_wr_idx] <= bp_wr_addr;
        end
    end
    assign bp_addr_in = {hold_bp[3], hold_bp[2], hold_bp[1], hold_bp[0]};

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compute the expected outcome of one request and update the model.
    task automatic model(input logic rd, input logic wr, input logic [2:0] num,
                         input logic [31:0] d, input logic ext);
        int eff;
        e_rd = '0; e_done = 0; e_ud = 0; e_gp = 0; e_db = 0; e_bpw = 0;
        e_bpi = '0; e_bpa = '0;
        if (!(rd || wr)) return;
        eff = num;
        if (num == 4 || num == 5) begin
            if (ext) begin e_ud = 1; return; end
            eff = num + 2;
        end
        if (m_ctl[13]) begin
            e_db = 1; m_ctl[13] = 1'b0; m_sts[13] = 1'b1;
            return;
        end
        if (wr) begin
            if (eff < 4) begin
                e_done = 1; e_bpw = 1; e_bpi = eff[1:0]; e_bpa = d;
                m_bp[eff] = d;
            end else if (eff == 6) begin
                if (d[12]) e_gp = 1;
                else begin e_done = 1; m_sts = d | 32'hFFFF_0FF0; end
            end else begin
                if (d[11] || d[12] || d[14] || d[15]) e_gp = 1;
                else begin e_done = 1; m_ctl = d | 32'h0000_0400; end
            end
        end else begin
            e_done = 1;
            if (eff < 4)       e_rd = m_bp[eff];
            else if (eff == 6) e_rd = m_sts;
            else               e_rd = m_ctl;
        end
    endtask

    // Entered at a falling edge; drives one request, compares one clock later.
    task automatic step(input string req, input logic rd, input logic wr,
                        input logic [2:0] num, input logic [31:0] d, input logic ext);
        dr_rd = rd; dr_wr = wr; dr_num = num; dr_wdata = d; ext_en = ext;
        model(rd, wr, num, d, ext);
        @(posedge clk);
        @(negedge clk);
        dr_rd = 0; dr_wr = 0;
        chk(req, "rd_data",  rd_data,  e_rd);
        chk(req, "acc_done", {31'd0, acc_done}, {31'd0, e_done});
        chk(req, "fault_ud", {31'd0, fault_ud}, {31'd0, e_ud});
        chk(req, "fault_gp", {31'd0, fault_gp}, {31'd0, e_gp});
        chk(req, "fault_db", {31'd0, fault_db}, {31'd0, e_db});
        chk(req, "bp_wr_en", {31'd0, bp_wr_en}, {31'd0, e_bpw});
        if (e_bpw) begin
            chk(req, "bp_wr_idx",  {30'd0, bp_wr_idx}, {30'd0, e_bpi});
            chk(req, "bp_wr_addr", bp_wr_addr, e_bpa);
        end
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 3'd0, 32'd0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        m_sts = 32'hFFFF_0FF0;
        m_ctl = 32'h0000_0400;
        for (int i = 0; i < NBP; i++) m_bp[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        idle("R1");
        step("R1", 1, 0, 3'd6, 32'd0, 0);
        step("R1", 1, 0, 3'd7, 32'd0, 0);

        // R5: forwarded address writes, no reserved check, readback
        step("R5", 0, 1, 3'd0, 32'hFFFF_FFFF, 0); idle("R5");
        step("R5", 0, 1, 3'd1, 32'h1234_5678, 0); idle("R5");
        step("R5", 0, 1, 3'd2, 32'h0000_D800, 1); idle("R5");
        step("R5", 0, 1, 3'd3, 32'hDEAD_BEEF, 0); idle("R5");
        for (int i = 0; i < 4; i++) step("R5", 1, 0, 3'(i), 32'd0, 0);

        // R7: status write ORs fixed ones
        step("R7", 0, 1, 3'd6, 32'h0000_E00F, 0);
        step("R7", 1, 0, 3'd6, 32'd0, 0);
        // R6: reserved bits fault, nothing stored
        step("R6", 0, 1, 3'd6, 32'h0000_1000, 0);
        step("R6", 0, 1, 3'd7, 32'h0000_0800, 0);
        step("R6", 0, 1, 3'd7, 32'h0000_1000, 0);
        step("R6", 0, 1, 3'd7, 32'h0000_4000, 0);
        step("R6", 0, 1, 3'd7, 32'h0000_8000, 0);
        step("R6", 1, 0, 3'd6, 32'd0, 0);
        step("R6", 1, 0, 3'd7, 32'd0, 0);
        // R8: control write ORs bit 10
        step("R8", 0, 1, 3'd7, 32'h0000_00FF, 0);
        step("R8", 1, 0, 3'd7, 32'd0, 0);

        // R2: aliases 4->6, 5->7
        step("R2", 0, 1, 3'd4, 32'h0000_0003, 0);
        step("R2", 1, 0, 3'd6, 32'd0, 0);
        step("R2", 0, 1, 3'd5, 32'h0000_0055, 0);
        step("R2", 1, 0, 3'd7, 32'd0, 0);
        step("R2", 1, 0, 3'd4, 32'd0, 0);
        step("R2", 1, 0, 3'd5, 32'd0, 0);

        // R3: extension on makes 4/5 undefined
        step("R3", 1, 0, 3'd4, 32'd0, 1);
        step("R3", 0, 1, 3'd5, 32'h0000_0000, 1);
        step("R3", 1, 0, 3'd7, 32'd0, 1);

        // R4: general-detect arms, UD wins first, then trap on a bp write
        step("R4", 0, 1, 3'd7, 32'h0000_2001, 0);
        step("R3", 1, 0, 3'd4, 32'd0, 1);
        step("R4", 0, 1, 3'd0, 32'hCAFE_0000, 0); idle("R4");
        step("R4", 1, 0, 3'd0, 32'd0, 0);
        step("R4", 1, 0, 3'd6, 32'd0, 0);
        step("R4", 1, 0, 3'd7, 32'd0, 0);
        // R4: trap on a read
        step("R4", 0, 1, 3'd7, 32'h0000_2000, 0);
        step("R4", 1, 0, 3'd6, 32'd0, 0);
        step("R4", 1, 0, 3'd7, 32'd0, 0);

        // R10: both strobes act as a write
        step("R10", 1, 1, 3'd6, 32'h0000_0004, 0);
        step("R10", 1, 0, 3'd6, 32'd0, 0);
        step("R10", 1, 1, 3'd1, 32'h0BAD_F00D, 0); idle("R10");
        step("R10", 1, 0, 3'd1, 32'd0, 0);

        // R9: mixed random traffic with idle gaps
        for (int n = 0; n < 600; n++) begin
            logic [31:0] d;
            logic [2:0]  num;
            num = 3'($urandom % 8);
            d = $urandom;
            if (($urandom % 4) != 0) d = d & ~32'h0000_F800;
            if (($urandom % 5) == 0) d = d | 32'h0000_2000;
            step("R9", 1'($urandom % 2), 1'($urandom % 2), num, d,
                 (($urandom % 3) == 0));
            idle("R9");
        end

        summary();
        $finish;
    end

endmodule